// File: doc/BRIEF.md
# Serial receive back end with overrun holding

This block sits behind the bit-level deserializer of an asynchronous serial receiver. The deserializer reports two events. The first is a pulse when it detects a start bit. The second is a pulse when a character is complete; this pulse carries eight data bits and parity-error, framing-error and break flags. The block stores each accepted character, data and flags together, in a receive queue of `DEPTH` entries. It presents the oldest entry to the host together with a ready flag, and it removes that entry on each read strobe.

When the queue is full, one more character can still be parked in a holding register. The receiver can therefore carry `DEPTH + 1` characters, 257 at the default depth. A start bit that arrives while both the queue and the holding register are occupied raises a sticky overrun flag at once, without waiting for that character to complete. If that character then completes, it replaces the parked one, and the queue itself is never overwritten.

Host commands enable or disable the receiver, reset the receiver, or clear the overrun flag. A disable takes effect at once and drops any character still being assembled. After an enable, the receiver only takes characters whose start bit arrives after the enable.

Top module: `uart_rx_backend`

## Requirements
- R1: After `rst`, `rx_ready` is 0, `overrun` is 0, `rx_enabled` is 0, and the head outputs are all 0.
- R2: An accepted character is stored in arrival order. While the queue is not empty, `rx_ready` is 1 and the head outputs show the oldest entry's data and its three flags, starting the cycle after the character is accepted. While the queue is empty, the head outputs are 0.
- R3: A `rd_strobe` with `rx_ready` high removes exactly one entry. A `rd_strobe` while `rx_ready` is low has no effect.
- R4: A character that completes while the queue holds `DEPTH` entries is parked in the holding register, so `DEPTH + 1` characters are kept. On the next read, the parked character enters the queue in the same cycle as the pop. No character is lost, and the order is preserved.
- R5: A character that completes while the queue is full and the holding register is occupied replaces the parked character. The entries in the queue are unchanged.
- R6: A `rx_start` while the receiver is enabled, the queue is full, the holding register is occupied and no read is taking place sets `overrun` in the next cycle. `overrun` then stays at 1 until `cmd_err_reset`.
- R7: `cmd_disable` clears `rx_enabled` in the next cycle. A character whose start bit came before the disable is dropped, and the entries already in the queue stay readable.
- R8: A character is accepted only if its `rx_start` was seen while the receiver was enabled, after the latest enable or disable. Start and completion pulses that arrive while the receiver is disabled are ignored.
- R9: `cmd_rx_reset` empties the queue and the holding register, drives `rx_ready` and the head outputs to 0, and leaves the receiver disabled. `overrun` is not affected.
- R10: `cmd_err_reset` clears `overrun`. If an overrun start bit arrives in the same cycle, setting wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_start | input | 1 | Start bit detected by the deserializer |
| char_valid | input | 1 | Character complete |
| char_data | input | 8 | Data bits of the completed character |
| char_perr | input | 1 | Parity error of the completed character |
| char_ferr | input | 1 | Framing error of the completed character |
| char_brk | input | 1 | Break flag of the completed character |
| cmd_enable | input | 1 | Enable the receiver |
| cmd_disable | input | 1 | Disable the receiver immediately |
| cmd_rx_reset | input | 1 | Receiver reset: flush queue and holding register, disable |
| cmd_err_reset | input | 1 | Clear the overrun flag |
| rd_strobe | input | 1 | Host read: pop the head entry |
| rx_ready | output | 1 | Queue not empty |
| rd_data | output | 8 | Data of the head entry |
| rd_perr | output | 1 | Parity error of the head entry |
| rd_ferr | output | 1 | Framing error of the head entry |
| rd_brk | output | 1 | Break flag of the head entry |
| overrun | output | 1 | Sticky overrun flag |
| rx_enabled | output | 1 | Receiver enabled |

## Verification
A fault in the queue pointers or the read bypass shows up one cycle after the write or pop, as a wrong head entry or a wrong `rx_ready`. A fault in the hand-over from the holding register shows up as a missing or repeated character in the 257-character drain after a full queue. A fault in the start-bit tracking shows up at the next completion pulse, as a character accepted after a disable or before a fresh start bit. A fault in the overrun logic shows up as `overrun` missing or late by one cycle after the start bit.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  localparam int DATA_W  = 8;
  localparam int ENTRY_W = DATA_W + 3;

  typedef struct packed {
    logic              brk;
    logic              ferr;
    logic              perr;
    logic [DATA_W-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/rxb_fifo.sv
module rxb_fifo
  import rxb_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      flush,
  input  logic      wr_en,
  input  rx_entry_t wr_data,
  input  logic      rd_en,
  output rx_entry_t head,
  output logic      full,
  output logic      empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [AW-1:0]      wp, rp, raddr;
  logic [CW-1:0]      cnt;
  logic [ENTRY_W-1:0] q;

  initial begin
    if (DEPTH != (1 << AW)) $error("DEPTH must be a power of two");
  end

  assign raddr = rd_en ? rp + AW'(1) : rp;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (wr_en && (wp == raddr)) q <= wr_data;
    else                        q <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_en) wp <= wp + AW'(1);
      if (rd_en) rp <= rp + AW'(1);
      cnt <= cnt + CW'(wr_en) - CW'(rd_en);
    end
  end

  assign head  = rx_entry_t'(q);
  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en) |-> !full);
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty);
  p_flush_empties_r9: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty);
endmodule

// File: rtl/rxb_hold.sv
module rxb_hold
  import rxb_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      flush,
  input  logic      char_acc,
  input  rx_entry_t char_in,
  input  logic      pop,
  input  logic      fifo_full,
  output logic      fifo_wr,
  output rx_entry_t fifo_wdata,
  output logic      hold_v
);
  rx_entry_t hold_q;

  always_comb begin
    fifo_wr    = 1'b0;
    fifo_wdata = char_in;
    if (!flush) begin
      if (hold_v && pop) begin
        fifo_wr    = 1'b1;
        fifo_wdata = hold_q;
      end else if (char_acc && (!fifo_full || pop)) begin
        fifo_wr = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      hold_v <= 1'b0;
    end else if (hold_v && pop) begin
      hold_v <= char_acc;
      if (char_acc) hold_q <= char_in;
    end else if (char_acc && fifo_full && !pop) begin
      hold_v <= 1'b1;
      hold_q <= char_in;
    end
  end

  p_hold_only_when_full_r4: assert property (@(posedge clk) disable iff (rst)
    hold_v |-> fifo_full);
  p_hold_drains_on_pop_r4: assert property (@(posedge clk) disable iff (rst)
    (hold_v && pop && !flush) |-> fifo_wr);
endmodule

// File: rtl/rxb_ctrl.sv
module rxb_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic cmd_enable,
  input  logic cmd_disable,
  input  logic cmd_rx_reset,
  input  logic cmd_err_reset,
  input  logic rx_start,
  input  logic char_valid,
  input  logic fifo_full,
  input  logic hold_v,
  input  logic pop,
  output logic en,
  output logic char_acc,
  output logic overrun
);
  logic armed;
  logic stop_now;
  logic ovr_set;

  assign stop_now = cmd_disable || cmd_rx_reset;
  assign char_acc = char_valid && armed && en && !stop_now;
  assign ovr_set  = rx_start && en && !stop_now && hold_v && fifo_full && !pop;

  always_ff @(posedge clk) begin
    if (rst || stop_now)       en <= 1'b0;
    else if (cmd_enable)       en <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || stop_now)       armed <= 1'b0;
    else if (rx_start && en)   armed <= 1'b1;
    else if (char_valid)       armed <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)                   overrun <= 1'b0;
    else if (ovr_set)          overrun <= 1'b1;
    else if (cmd_err_reset)    overrun <= 1'b0;
  end

  p_overrun_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (overrun && !cmd_err_reset) |=> overrun);
  p_overrun_from_start_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(rx_start));
  p_disabled_no_accept_r7: assert property (@(posedge clk) disable iff (rst)
    !en |-> !char_acc);
  p_disable_now_r7: assert property (@(posedge clk) disable iff (rst)
    cmd_disable |=> !en);
endmodule

// File: rtl/uart_rx_backend.sv
module uart_rx_backend
  import rxb_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_start,
  input  logic              char_valid,
  input  logic [DATA_W-1:0] char_data,
  input  logic              char_perr,
  input  logic              char_ferr,
  input  logic              char_brk,
  input  logic              cmd_enable,
  input  logic              cmd_disable,
  input  logic              cmd_rx_reset,
  input  logic              cmd_err_reset,
  input  logic              rd_strobe,
  output logic              rx_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_perr,
  output logic              rd_ferr,
  output logic              rd_brk,
  output logic              overrun,
  output logic              rx_enabled
);
  rx_entry_t char_in, wdata, head;
  logic      char_acc, fifo_wr, hold_v, full, empty, pop;

  assign char_in = '{brk: char_brk, ferr: char_ferr, perr: char_perr, data: char_data};
  assign rx_ready = !empty;
  assign pop      = rd_strobe && rx_ready && !cmd_rx_reset;

  rxb_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .cmd_enable(cmd_enable), .cmd_disable(cmd_disable),
    .cmd_rx_reset(cmd_rx_reset), .cmd_err_reset(cmd_err_reset),
    .rx_start(rx_start), .char_valid(char_valid),
    .fifo_full(full), .hold_v(hold_v), .pop(pop),
    .en(rx_enabled), .char_acc(char_acc), .overrun(overrun)
  );

  rxb_hold u_hold (
    .clk(clk), .rst(rst), .flush(cmd_rx_reset),
    .char_acc(char_acc), .char_in(char_in), .pop(pop), .fifo_full(full),
    .fifo_wr(fifo_wr), .fifo_wdata(wdata), .hold_v(hold_v)
  );

  rxb_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .flush(cmd_rx_reset),
    .wr_en(fifo_wr), .wr_data(wdata), .rd_en(pop),
    .head(head), .full(full), .empty(empty)
  );

  assign rd_data = rx_ready ? head.data : '0;
  assign rd_perr = rx_ready && head.perr;
  assign rd_ferr = rx_ready && head.ferr;
  assign rd_brk  = rx_ready && head.brk;

  p_ready_drops_on_reset_r9: assert property (@(posedge clk) disable iff (rst)
    cmd_rx_reset |=> (!rx_ready && !rx_enabled));
  p_accept_sets_ready_r2: assert property (@(posedge clk) disable iff (rst)
    (char_acc && !cmd_rx_reset) |=> rx_ready);
endmodule

// File: tb/tb_uart_rx_backend.sv
module tb_uart_rx_backend;
  import rxb_pkg::*;
  localparam int DEPTH = 256;

  logic clk = 1'b0;
  logic rst;
  logic rx_start, char_valid, cmd_enable, cmd_disable, cmd_rx_reset, cmd_err_reset, rd_strobe;
  logic [7:0] char_data;
  logic char_perr, char_ferr, char_brk;
  logic rx_ready, rd_perr, rd_ferr, rd_brk, overrun, rx_enabled;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  rx_entry_t mq[$];
  rx_entry_t m_hold;
  bit m_holdv, m_en, m_armed, m_ovr;

  always #2.5 clk = ~clk;

  uart_rx_backend #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .rx_start(rx_start), .char_valid(char_valid),
    .char_data(char_data), .char_perr(char_perr), .char_ferr(char_ferr), .char_brk(char_brk),
    .cmd_enable(cmd_enable), .cmd_disable(cmd_disable), .cmd_rx_reset(cmd_rx_reset),
    .cmd_err_reset(cmd_err_reset), .rd_strobe(rd_strobe),
    .rx_ready(rx_ready), .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr),
    .rd_brk(rd_brk), .overrun(overrun), .rx_enabled(rx_enabled)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic rx_entry_t cur_in();
    return '{brk: char_brk, ferr: char_ferr, perr: char_perr, data: char_data};
  endfunction

  // Expected-state update from the requirements, using inputs of this cycle.
  function automatic void model_step();
    bit pop, accept, ovr_set;
    pop = rd_strobe && (mq.size() > 0) && !cmd_rx_reset;
    if (cmd_rx_reset) begin
      mq.delete();
      m_holdv = 0; m_en = 0; m_armed = 0;
      if (cmd_err_reset) m_ovr = 0;
      return;
    end
    accept  = char_valid && m_armed && m_en && !cmd_disable;
    ovr_set = rx_start && m_en && !cmd_disable && m_holdv && (mq.size() == DEPTH) && !pop;
    if (pop) void'(mq.pop_front());
    if (pop && m_holdv) begin mq.push_back(m_hold); m_holdv = 0; end
    if (accept) begin
      if (mq.size() < DEPTH) mq.push_back(cur_in());
      else begin m_hold = cur_in(); m_holdv = 1; end
    end
    if (cmd_disable) m_armed = 0;
    else if (rx_start && m_en) m_armed = 1;
    else if (char_valid) m_armed = 0;
    if (cmd_disable) m_en = 0;
    else if (cmd_enable) m_en = 1;
    if (ovr_set) m_ovr = 1;
    else if (cmd_err_reset) m_ovr = 0;
  endfunction

  task automatic compare(input string req);
    rx_entry_t e;
    e = (mq.size() > 0) ? mq[0] : '0;
    chk(rx_ready == (mq.size() > 0), req, "rx_ready", 32'(rx_ready), 32'(mq.size() > 0));
    chk({rd_brk, rd_ferr, rd_perr, rd_data} == e, req, "head entry",
        32'({rd_brk, rd_ferr, rd_perr, rd_data}), 32'(e));
    chk(overrun == m_ovr, req, "overrun", 32'(overrun), 32'(m_ovr));
    chk(rx_enabled == m_en, req, "rx_enabled", 32'(rx_enabled), 32'(m_en));
  endtask

  task automatic clear_in();
    rx_start = 0; char_valid = 0; cmd_enable = 0; cmd_disable = 0;
    cmd_rx_reset = 0; cmd_err_reset = 0; rd_strobe = 0;
  endtask

  task automatic step(input string req);
    model_step();
    @(posedge clk); #1;
    compare(req);
    clear_in();
  endtask

  task automatic set_char(input logic [10:0] v);
    {char_brk, char_ferr, char_perr, char_data} = v;
  endtask

  task automatic send(input logic [10:0] v, input string req);
    rx_start = 1; step(req);
    step(req);
    char_valid = 1; set_char(v); step(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    clear_in(); set_char('0);
    rst = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    mq.delete(); m_holdv = 0; m_en = 0; m_armed = 0; m_ovr = 0;
    compare("R1");

    // R3: read with empty queue is ignored
    rd_strobe = 1; step("R3");
    // R2: ordering and flag fields
    cmd_enable = 1; step("R2");
    send(11'h4A5, "R2");
    send(11'h23C, "R2");
    send(11'h100, "R2");
    rd_strobe = 1; step("R3");
    rd_strobe = 1; step("R3");
    rd_strobe = 1; step("R3");
    rd_strobe = 1; step("R3");

    // R4: DEPTH entries plus one parked
    for (int i = 0; i <= DEPTH; i++) send(11'(i * 37 + 5), "R4");
    chk(rx_ready == 1, "R4", "ready when full", 32'(rx_ready), 1);
    // R6: start bit while full and held raises overrun next cycle
    rx_start = 1; step("R6");
    chk(overrun == 1, "R6", "overrun on start", 32'(overrun), 1);
    step("R6");
    // R5: completed overrun char replaces the parked one
    char_valid = 1; set_char(11'h7EE); step("R5");
    for (int i = 0; i <= DEPTH; i++) begin rd_strobe = 1; step("R4"); end
    chk(rx_ready == 0, "R4", "drained after DEPTH+1 reads", 32'(rx_ready), 0);
    chk(overrun == 1, "R6", "overrun sticky", 32'(overrun), 1);
    cmd_err_reset = 1; step("R10");

    // R7: disable mid-character keeps queue
    send(11'h055, "R7");
    rx_start = 1; step("R7");
    cmd_disable = 1; step("R7");
    char_valid = 1; set_char(11'h0AA); step("R7");
    // R8: start while disabled, then enable: not accepted
    rx_start = 1; step("R8");
    cmd_enable = 1; step("R8");
    char_valid = 1; set_char(11'h0CC); step("R8");
    send(11'h0DD, "R8");
    rd_strobe = 1; step("R7");

    // R9: receiver reset
    send(11'h611, "R9");
    rx_start = 1; step("R9");
    cmd_rx_reset = 1; step("R9");
    chk(rx_ready == 0 && rd_data == 0, "R9", "ready/head after rx reset",
        32'({rx_ready, rd_data}), 0);
    char_valid = 1; set_char(11'h0EE); step("R9");

    // Random mix
    cmd_enable = 1; step("R2");
    for (int i = 0; i < 6000; i++) begin
      rx_start      = ($urandom_range(99) < 30);
      char_valid    = ($urandom_range(99) < 30);
      set_char(11'($urandom));
      rd_strobe     = ($urandom_range(99) < 15);
      cmd_enable    = ($urandom_range(99) < 4);
      cmd_disable   = ($urandom_range(999) < 5);
      cmd_rx_reset  = ($urandom_range(999) < 2);
      cmd_err_reset = ($urandom_range(99) < 2);
      step("R2");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule